// File: doc/BRIEF.md
# Button-Driven Paddle Position Generator

This block generates the vertical paddle video for one player of a two-player ball-and-paddle video game. In the classic circuit a rotary control set the period of an analog one-shot timer. Here a digital delay counter takes over that role. At the top of every frame it is loaded with the paddle's position, expressed as a number of primary pixel clocks. When the count runs out, the next horizontal line strobe starts a line counter, and that counter holds the paddle on for a fixed number of lines. The paddle output is that line interval gated by the horizontal paddle-column window.

The position comes from buttons, not a dial. Up and down move the paddle by a coarse step once per frame, and a fine input held with either button shrinks the step. The position saturates at both limits. Two option inputs change the shape. One doubles the paddle height. The other applies only to an instance built with the training variant: it stretches the paddle over most of its side of the screen, leaving a gap only above it.

All state runs on the fast synchronizing clock `clk_i`, which is four times the pixel rate. The primary pixel clock reaches the block as the enable `pix_en_i`. The line and frame strobes are taken only in cycles where that enable is high.

Top module: `paddle_pos_gen`

## Requirements
- R1: After reset the position holds POS_INIT. While no frame strobe has arrived, `paddle_o` stays low even with `col_win_i` high.
- R2: In a frame, the paddle's first line (lines counted from 0 at the frame strobe) equals the position held before that frame's strobe. Button changes sampled at a frame strobe appear in the next frame.
- R3: With no option set, the paddle lasts BASE_H (16) consecutive lines.
- R4: With `extend_i` high, the paddle lasts 2*BASE_H (32) consecutive lines.
- R5: At each frame strobe, `down_i` alone increases the position by COARSE_STEP (4) lines and `up_i` alone decreases it by 4. The position changes at no other time.
- R6: With `fine_i` high, the step is FINE_STEP (1) line instead.
- R7: The position saturates at POS_MIN and POS_MAX and never leaves that range.
- R8: With both `up_i` and `down_i` high, or both low, the position does not change at a frame strobe.
- R9: When TRAIN_EN is 1 and `train_i` is high, the paddle starts at line TRAIN_TOP and lasts TRAIN_H lines, whatever the position. When TRAIN_EN is 0, `train_i` has no effect.
- R10: `paddle_o` is high only while `col_win_i` is high. With the window never opened in a frame, no paddle line appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Synchronizing clock, 4x pixel rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pix_en_i | input | 1 | Primary pixel clock enable, one cycle in four |
| line_i | input | 1 | Horizontal line strobe, qualified by pix_en_i |
| frame_i | input | 1 | Frame start strobe, coincides with line 0 strobe |
| col_win_i | input | 1 | Horizontal paddle-column window |
| up_i | input | 1 | Move paddle up |
| down_i | input | 1 | Move paddle down |
| fine_i | input | 1 | Select fine step |
| extend_i | input | 1 | Double paddle height |
| train_i | input | 1 | Training paddle (TRAIN_EN variant only) |
| paddle_o | output | 1 | Paddle video |

## Verification
Each kind of internal corruption shows up at the ports in a recognizable way. A wrong position register or a wrong delay load moves the paddle's first line. A delay counter that never reaches zero, or retriggers, removes the paddle or repeats it. A line counter with a bad load or a bad decrement gives the wrong height. Each of these is visible within the first frame after the fault, so the bench rebuilds the per-line paddle profile of every frame and compares its first line and length with a model of the button history. Saturation and the hold cases are driven across several frames, because a step error there only grows frame by frame.

// File: rtl/paddle_pkg.sv
package paddle_pkg;

  typedef enum logic [1:0] {
    MV_HOLD = 2'd0,
    MV_UP   = 2'd1,
    MV_DOWN = 2'd2
  } move_e;

  // conflicting or idle buttons hold position
  function automatic move_e decode_move(input logic up, input logic dn);
    if (up && !dn) return MV_UP;
    if (dn && !up) return MV_DOWN;
    return MV_HOLD;
  endfunction

endpackage

// File: rtl/paddle_pos_reg.sv
module paddle_pos_reg
  import paddle_pkg::*;
#(
  parameter int POS_W       = 9,
  parameter int POS_MIN     = 16,
  parameter int POS_MAX     = 200,
  parameter int POS_INIT    = 100,
  parameter int COARSE_STEP = 4,
  parameter int FINE_STEP   = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  logic             up_i,
  input  logic             down_i,
  input  logic             fine_i,
  output logic [POS_W-1:0] pos_o
);

  logic [POS_W-1:0] pos_q, pos_d;
  move_e            mv;
  int               step, cur, nxt;

  always_comb begin
    mv   = decode_move(up_i, down_i);
    step = fine_i ? FINE_STEP : COARSE_STEP;
    cur  = int'(pos_q);
    nxt  = cur;
    case (mv)
      MV_UP:   nxt = (cur - step < POS_MIN) ? POS_MIN : cur - step;
      MV_DOWN: nxt = (cur + step > POS_MAX) ? POS_MAX : cur + step;
      default: nxt = cur;
    endcase
    pos_d = POS_W'(nxt);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pos_q <= POS_W'(POS_INIT);
    else if (upd_i) pos_q <= pos_d;
  end

  assign pos_o = pos_q;

  // R7
  pos_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_q >= POS_W'(POS_MIN)) && (pos_q <= POS_W'(POS_MAX)));

  // R5
  pos_frame_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(pos_q));

  // R8
  pos_conflict_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && (up_i == down_i)) |=> $stable(pos_q));

endmodule

// File: rtl/paddle_delay.sv
module paddle_delay #(
  parameter int POS_W    = 9,
  parameter int LINE_PIX = 455,
  parameter int DLY_W    = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             tick_i,
  input  logic [POS_W-1:0] top_i,
  output logic             done_o
);

  logic [DLY_W-1:0] dly_q;

  // expires on the pixel tick just before line top_i begins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     dly_q <= '0;
    else if (load_i)                 dly_q <= DLY_W'(int'(top_i) * LINE_PIX - 1);
    else if (tick_i && dly_q != '0)  dly_q <= dly_q - 1'b1;
  end

  assign done_o = (dly_q == '0);

  // R2
  dly_oneshot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && dly_q == '0) |=> (dly_q == '0));

  // R2
  dly_tick_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !tick_i) |=> $stable(dly_q));

endmodule

// File: rtl/paddle_height.sv
module paddle_height #(
  parameter int HGT_W   = 8,
  parameter int HGT_MAX = 200
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_i,
  input  logic             line_i,
  input  logic             dly_done_i,
  input  logic [HGT_W-1:0] hgt_i,
  input  logic             col_win_i,
  output logic             video_o
);

  logic             ln_en_q, armed_q, start;
  logic [HGT_W-1:0] hcnt_q;

  // line enable registered so the counter never sees a derived clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ln_en_q <= 1'b0;
    else         ln_en_q <= line_i;
  end

  assign start = ln_en_q && armed_q && dly_done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      hcnt_q  <= '0;
    end else if (frame_i) begin
      armed_q <= 1'b1;
      hcnt_q  <= '0;
    end else if (start) begin
      armed_q <= 1'b0;
      hcnt_q  <= hgt_i;
    end else if (ln_en_q && hcnt_q != '0) begin
      hcnt_q  <= hcnt_q - 1'b1;
    end
  end

  assign video_o = (hcnt_q != '0) && col_win_i;

  // R3
  hcnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hcnt_q <= HGT_W'(HGT_MAX));

  // R3
  hcnt_line_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ln_en_q && !frame_i) |=> $stable(hcnt_q));

  // R1
  no_start_unarmed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_q && !frame_i && hcnt_q == '0) |=> (hcnt_q == '0));

endmodule

// File: rtl/paddle_pos_gen.sv
module paddle_pos_gen #(
  parameter int LINE_PIX    = 455,
  parameter int POS_W       = 9,
  parameter int POS_MIN     = 16,
  parameter int POS_MAX     = 200,
  parameter int POS_INIT    = 100,
  parameter int BASE_H      = 16,
  parameter int COARSE_STEP = 4,
  parameter int FINE_STEP   = 1,
  parameter int TRAIN_EN    = 1,
  parameter int TRAIN_TOP   = 40,
  parameter int TRAIN_H     = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pix_en_i,
  input  logic line_i,
  input  logic frame_i,
  input  logic col_win_i,
  input  logic up_i,
  input  logic down_i,
  input  logic fine_i,
  input  logic extend_i,
  input  logic train_i,
  output logic paddle_o
);

  localparam int MAX_TOP = (POS_MAX > TRAIN_TOP) ? POS_MAX : TRAIN_TOP;
  localparam int DLY_W   = $clog2(MAX_TOP * LINE_PIX + 1);
  localparam int HGT_MAX = (2 * BASE_H > TRAIN_H) ? 2 * BASE_H : TRAIN_H;
  localparam int HGT_W   = $clog2(HGT_MAX + 1);

  logic             frame_tick, line_tick, dly_done;
  logic [POS_W-1:0] pos, top_sel;
  logic [HGT_W-1:0] hgt_sel, hgt_norm;

  assign frame_tick = pix_en_i && frame_i;
  assign line_tick  = pix_en_i && line_i;
  assign hgt_norm   = extend_i ? HGT_W'(2 * BASE_H) : HGT_W'(BASE_H);

  generate
    if (TRAIN_EN != 0) begin : g_train
      always_comb begin
        top_sel = train_i ? POS_W'(TRAIN_TOP) : pos;
        hgt_sel = train_i ? HGT_W'(TRAIN_H)   : hgt_norm;
      end
    end else begin : g_plain
      always_comb begin
        top_sel = pos;
        hgt_sel = hgt_norm;
      end
    end
  endgenerate

  paddle_pos_reg #(
    .POS_W      (POS_W),
    .POS_MIN    (POS_MIN),
    .POS_MAX    (POS_MAX),
    .POS_INIT   (POS_INIT),
    .COARSE_STEP(COARSE_STEP),
    .FINE_STEP  (FINE_STEP)
  ) u_pos (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .upd_i (frame_tick),
    .up_i  (up_i),
    .down_i(down_i),
    .fine_i(fine_i),
    .pos_o (pos)
  );

  paddle_delay #(
    .POS_W   (POS_W),
    .LINE_PIX(LINE_PIX),
    .DLY_W   (DLY_W)
  ) u_dly (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(frame_tick),
    .tick_i(pix_en_i),
    .top_i (top_sel),
    .done_o(dly_done)
  );

  paddle_height #(
    .HGT_W  (HGT_W),
    .HGT_MAX(HGT_MAX)
  ) u_hgt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .frame_i   (frame_tick),
    .line_i    (line_tick),
    .dly_done_i(dly_done),
    .hgt_i     (hgt_sel),
    .col_win_i (col_win_i),
    .video_o   (paddle_o)
  );

  // R10
  video_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(col_win_i) |-> !paddle_o);

endmodule

// File: tb/paddle_pos_gen_tb_top.sv
module paddle_pos_gen_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int LP   = 8;
  localparam int FL   = 80;
  localparam int PMIN = 4;
  localparam int PMAX = 40;
  localparam int PINI = 20;
  localparam int BH   = 16;
  localparam int CST  = 4;
  localparam int FST  = 1;
  localparam int TTOP = 6;
  localparam int TH   = 66;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pix_en_i = 0, line_i = 0, frame_i = 0, col_win_i = 0;
  logic up_i = 0, down_i = 0, fine_i = 0, extend_i = 0, train_i = 0;
  logic pad_a, pad_b;

  always #(CLK_PERIOD/2) clk = ~clk;

  paddle_pos_gen #(
    .LINE_PIX(LP), .POS_W(8), .POS_MIN(PMIN), .POS_MAX(PMAX), .POS_INIT(PINI),
    .BASE_H(BH), .COARSE_STEP(CST), .FINE_STEP(FST), .TRAIN_EN(1),
    .TRAIN_TOP(TTOP), .TRAIN_H(TH)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .pix_en_i(pix_en_i), .line_i(line_i),
    .frame_i(frame_i), .col_win_i(col_win_i), .up_i(up_i), .down_i(down_i),
    .fine_i(fine_i), .extend_i(extend_i), .train_i(train_i), .paddle_o(pad_a)
  );

  paddle_pos_gen #(
    .LINE_PIX(LP), .POS_W(8), .POS_MIN(PMIN), .POS_MAX(PMAX), .POS_INIT(PINI),
    .BASE_H(BH), .COARSE_STEP(CST), .FINE_STEP(FST), .TRAIN_EN(0),
    .TRAIN_TOP(TTOP), .TRAIN_H(TH)
  ) dut_p1_i (
    .clk_i(clk), .rst_ni(rst_ni), .pix_en_i(pix_en_i), .line_i(line_i),
    .frame_i(frame_i), .col_win_i(col_win_i), .up_i(up_i), .down_i(down_i),
    .fine_i(fine_i), .extend_i(extend_i), .train_i(train_i), .paddle_o(pad_b)
  );

  int n_checks = 0, n_err = 0;
  bit gen_on = 0, rec_ok = 0, col_en = 1, bad_col = 0;
  bit rec_a [FL], rec_b [FL];
  int res_top [2], res_h [2], res_gap [2];
  int mpos = PINI;
  event frame_ev;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void summarize(input int idx);
    int top = -1, h = 0, last = -1;
    for (int l = 0; l < FL; l++) begin
      if ((idx == 0) ? rec_a[l] : rec_b[l]) begin
        if (top < 0) top = l;
        h++;
        last = l;
      end
    end
    res_top[idx] = top;
    res_h[idx]   = h;
    res_gap[idx] = (h == 0) ? 0 : (last - top + 1 - h);
  endfunction

  // timing generator and per-line sampler
  initial begin
    int div = 3, px = LP - 1, ln = FL - 1;
    forever begin
      @(negedge clk);
      if (gen_on) begin
        if (rec_ok && div == 3 && px == 5) begin
          rec_a[ln] = pad_a;
          rec_b[ln] = pad_b;
        end
        if (rec_ok && !col_win_i && (pad_a || pad_b)) bad_col = 1;
        div++;
        if (div == 4) begin
          div = 0;
          px++;
          if (px == LP) begin
            px = 0;
            ln++;
            if (ln == FL) begin
              ln = 0;
              if (rec_ok) begin
                summarize(0);
                summarize(1);
                ->frame_ev;
              end
              rec_ok = 1;
              for (int l = 0; l < FL; l++) begin
                rec_a[l] = 0;
                rec_b[l] = 0;
              end
            end
          end
        end
        pix_en_i  = (div == 0);
        line_i    = (div == 0) && (px == 0);
        frame_i   = (div == 0) && (px == 0) && (ln == 0);
        col_win_i = col_en && (px >= 3) && (px <= 5);
      end
    end
  end

  function automatic int model_step(input int p, input bit up, input bit dn, input bit fn);
    int s = fn ? FST : CST;
    if (up && !dn) return (p - s < PMIN) ? PMIN : p - s;
    if (dn && !up) return (p + s > PMAX) ? PMAX : p + s;
    return p;
  endfunction

  // one frame with buttons as currently driven; checks both instances
  task automatic do_frame(input string req);
    int exp_top = mpos;
    int exp_h   = extend_i ? 2 * BH : BH;
    int ta, ha, tb, hb;
    bad_col = 0;
    mpos = model_step(mpos, up_i, down_i, fine_i);
    ta = train_i ? TTOP : exp_top;
    ha = train_i ? TH : exp_h;
    tb = exp_top;
    hb = exp_h;
    if (!col_en) begin
      ta = -1; ha = 0; tb = -1; hb = 0;
    end
    @(frame_ev);
    chk(res_top[0] == ta, {req, " top p2"}, res_top[0], ta);
    chk(res_h[0] == ha,   {req, " height p2"}, res_h[0], ha);
    chk(res_top[1] == tb, {req, " top p1"}, res_top[1], tb);
    chk(res_h[1] == hb,   {req, " height p1"}, res_h[1], hb);
    chk(res_gap[0] == 0 && res_gap[1] == 0, {req, " contiguous"}, res_gap[0] + res_gap[1], 0);
    chk(!bad_col, "R10 video outside window", int'(bad_col), 0);
  endtask

  task automatic set_btn(input bit up, input bit dn, input bit fn);
    up_i = up; down_i = dn; fine_i = fn;
  endtask

  task automatic t_reset();
    rst_ni = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    col_win_i = 1;
    pix_en_i = 1;
    line_i = 1;
    repeat (20) begin
      @(negedge clk);
      chk(!pad_a && !pad_b, "R1 no paddle before frame", int'(pad_a || pad_b), 0);
    end
    col_win_i = 0; pix_en_i = 0; line_i = 0;
    @(negedge clk);
    gen_on = 1;
  endtask

  task automatic t_idle();
    set_btn(0, 0, 0);
    do_frame("R1 R2 R3 idle");
    do_frame("R2 R3 idle");
  endtask

  task automatic t_coarse();
    set_btn(0, 1, 0);
    repeat (3) do_frame("R5 down");
    set_btn(0, 0, 0);
    do_frame("R5 released");
    set_btn(1, 0, 0);
    repeat (2) do_frame("R5 up");
    set_btn(0, 0, 0);
    do_frame("R5 settle");
  endtask

  task automatic t_fine();
    set_btn(0, 1, 1);
    repeat (3) do_frame("R6 fine down");
    set_btn(1, 0, 1);
    do_frame("R6 fine up");
    set_btn(0, 0, 0);
    do_frame("R6 settle");
  endtask

  task automatic t_both();
    set_btn(1, 1, 0);
    repeat (2) do_frame("R8 both held");
    set_btn(0, 0, 0);
    do_frame("R8 settle");
  endtask

  task automatic t_sat_hi();
    set_btn(0, 1, 0);
    repeat (8) do_frame("R7 top limit");
    set_btn(0, 0, 0);
    do_frame("R7 hold at max");
  endtask

  task automatic t_extend();
    extend_i = 1;
    repeat (2) do_frame("R4 extended");
    extend_i = 0;
  endtask

  task automatic t_sat_lo();
    set_btn(1, 0, 0);
    repeat (11) do_frame("R7 bottom limit");
    set_btn(0, 0, 0);
    do_frame("R7 hold at min");
  endtask

  task automatic t_train();
    train_i = 1;
    set_btn(0, 1, 0);
    do_frame("R9 training moving");
    set_btn(0, 0, 0);
    do_frame("R9 training");
    train_i = 0;
    do_frame("R9 training off");
  endtask

  task automatic t_colwin();
    col_en = 0;
    do_frame("R10 window closed");
    col_en = 1;
    do_frame("R10 window open");
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  initial begin
    t_reset();
    t_idle();
    t_coarse();
    t_fine();
    t_both();
    t_sat_hi();
    t_extend();
    t_sat_lo();
    t_train();
    t_colwin();
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 190000);
    n_checks++;
    n_err++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

endmodule